// File: doc/BRIEF.md
# Programmable Multi-Lane Test Pattern Source

This block sits in front of a wide sample stream and can replace it with a known test pattern. A host loads a table of 1024 eight-bit samples through a 32-bit register bus. When the generator runs, it advances through the table by one entry for each valid input cycle. Each of 64 output lanes is built from the shared table sample: the lane's own offset is added first, and the sum is then shifted left by a shift amount that all lanes share. Both the add and the shift wrap at the lane width.

When the generator is stopped, the live input lanes pass through with the same two-cycle latency. The downstream logic therefore sees an identical timing relationship in both modes. A control register holds two separate bits. One starts and stops the pattern. The other is a stream-locked flag that stays set while the pattern is stopped. The host can rewrite the table while the pattern runs, and the sample sequence does not stall.

Top module: `lane_pattern_source`

## Requirements
- R1: Table word k sits at byte address 4*k (0x000 to 0x3FC). Byte j of the word (bits 8*j+7 down to 8*j) holds sample 4*k+j. A read returns the word with the same byte order, with `bus_rvalid` high one cycle after `bus_rd`.
- R2: The control register is at 0x404-4 = 0x400. Bit 0 is run and bit 1 is the lock flag. Both reset to 0, and reading the register returns them in those bit positions. `lock_flag` mirrors bit 1.
- R3: While running, the output for lane i is ((sample + offset_i) mod 2^LANE_W) shifted left by the shift amount, mod 2^LANE_W. It appears on `out_data[8*i+7:8*i]` two cycles after the input cycle that fetched the sample.
- R4: While running, the table index advances by one on each cycle with `in_valid` high and holds on cycles with `in_valid` low. It wraps from 1023 to 0.
- R5: A control write that changes bit 0 from 0 to 1 sets the index to 0, so the first valid cycle uses sample 0. Writing run=1 while the generator already runs does not reset the index.
- R6: While run is 0, `out_data` equals `in_data` from two cycles earlier. In both modes `out_valid` equals `in_valid` from two cycles earlier.
- R7: The shift amount is at 0x404 (bits 3:0) and resets to 4. A shift amount of LANE_W or more makes every running lane output 0.
- R8: Lane n's offset is at 0x800 + 4*n (bits 7:0) and resets to 0. With all offsets zero, every lane carries the same value.
- R9: A bus write to the table while the generator runs takes effect without a stall. A sample fetched in the same cycle as a write to its word returns the old content.
- R10: After reset, `out_valid`, `out_data`, `bus_rdata`, `bus_rvalid` and `lock_flag` are all 0.
- R11: A write to an unmapped or misaligned address changes nothing. A read from such an address returns 0 with `bus_rvalid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register bus write strobe |
| bus_rd | input | 1 | Register bus read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| in_valid | input | 1 | Live stream valid |
| in_data | input | 512 | Live stream, 64 lanes of 8 bits |
| out_valid | output | 1 | Output valid, two cycles after in_valid |
| out_data | output | 512 | Output lanes |
| lock_flag | output | 1 | Stream-locked flag from control bit 1 |

## Verification
The table is filled so that every byte within a word differs. A byte-order or word-address error therefore shows up both on readback and in the lane values. The per-lane offsets form a ramp, which separates the lanes from one another. A later all-zero offset setting must make the lanes identical. The stream is driven in two ways: a continuous valid stream, long enough to wrap the table, and a gapped stream. Together they distinguish advancing on every cycle from advancing only on valid cycles. Restart writes, repeated start writes, shift values up to and beyond the lane width, and table writes while running each exercise a separate path, all checked against a cycle-by-cycle model.

// File: rtl/tpg_pkg.sv
`timescale 1ns/1ps
package tpg_pkg;
  localparam int BUS_AW = 12;
  localparam int BUS_DW = 32;
  localparam int SMP_W = 8;
  localparam int SMP_PER_WORD = BUS_DW / SMP_W;
  localparam int SEL_W = $clog2(SMP_PER_WORD);

  localparam logic [BUS_AW-1:0] CTRL_ADDR  = 12'h400;
  localparam logic [BUS_AW-1:0] SHIFT_ADDR = 12'h404;
  localparam logic [3:0]        OFFS_PAGE  = 4'h8;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_MEM  = 2'd1,
    RD_REG  = 2'd2
  } rd_src_e;
endpackage

// File: rtl/tpg_pattern_mem.sv
`timescale 1ns/1ps
module tpg_pattern_mem #(
  parameter int WORDS = 256,
  parameter int DW    = 32,
  localparam int WA_W = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [WA_W-1:0] bus_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [WA_W-1:0] pat_addr,
  output logic [DW-1:0]   bus_q,
  output logic [DW-1:0]   pat_q
);
  logic [DW-1:0] mem [WORDS];

  // read-first on both ports: a read in the write cycle sees old data
  always_ff @(posedge clk) begin
    if (wr_en) mem[bus_addr] <= wr_data;
    bus_q <= mem[bus_addr];
    pat_q <= mem[pat_addr];
  end
endmodule

// File: rtl/tpg_regfile.sv
`timescale 1ns/1ps
module tpg_regfile
  import tpg_pkg::*;
#(
  parameter int LANES      = 64,
  parameter int LANE_W     = 8,
  parameter int SHIFT_W    = 4,
  parameter int SHIFT_INIT = 4,
  parameter int MEM_WORDS  = 256,
  localparam int WA_W = $clog2(MEM_WORDS),
  localparam int LN_W = $clog2(LANES)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [BUS_AW-1:0]             bus_addr,
  input  logic [BUS_DW-1:0]             bus_wdata,
  input  logic [BUS_DW-1:0]             mem_bus_q,
  output logic                          mem_we,
  output logic [WA_W-1:0]               mem_addr,
  output logic [BUS_DW-1:0]             mem_wdata,
  output logic                          run,
  output logic                          lock,
  output logic                          restart,
  output logic [SHIFT_W-1:0]            shamt,
  output logic [LANES-1:0][LANE_W-1:0]  offs,
  output logic [BUS_DW-1:0]             bus_rdata,
  output logic                          bus_rvalid
);
  logic            aligned, hit_mem, hit_ctrl, hit_shift, hit_offs;
  logic [LN_W-1:0] lane_idx;
  logic [BUS_DW-1:0] reg_view, reg_q;
  rd_src_e         rd_src;

  always_comb begin
    aligned   = (bus_addr[1:0] == 2'b00);
    hit_mem   = aligned && (bus_addr < BUS_AW'(4 * MEM_WORDS));
    hit_ctrl  = (bus_addr == CTRL_ADDR);
    hit_shift = (bus_addr == SHIFT_ADDR);
    hit_offs  = aligned && (bus_addr[11:8] == OFFS_PAGE) && (int'(bus_addr[7:2]) < LANES);
    lane_idx  = LN_W'(bus_addr[7:2]);
  end

  assign mem_addr  = bus_addr[WA_W+1:2];
  assign mem_we    = bus_wr && hit_mem;
  assign mem_wdata = bus_wdata;
  assign restart   = bus_wr && hit_ctrl && bus_wdata[0] && !run;

  always_comb begin
    reg_view = '0;
    if (hit_ctrl)       reg_view = {{(BUS_DW-2){1'b0}}, lock, run};
    else if (hit_shift) reg_view = BUS_DW'(shamt);
    else if (hit_offs)  reg_view = BUS_DW'(offs[lane_idx]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run        <= 1'b0;
      lock       <= 1'b0;
      shamt      <= SHIFT_W'(SHIFT_INIT);
      offs       <= '0;
      rd_src     <= RD_NONE;
      reg_q      <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      if (bus_wr && hit_ctrl) begin
        run  <= bus_wdata[0];
        lock <= bus_wdata[1];
      end
      if (bus_wr && hit_shift) shamt <= bus_wdata[SHIFT_W-1:0];
      if (bus_wr && hit_offs)  offs[lane_idx] <= bus_wdata[LANE_W-1:0];
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        rd_src <= hit_mem ? RD_MEM : RD_REG;
        reg_q  <= reg_view;
      end else begin
        rd_src <= RD_NONE;
        reg_q  <= '0;
      end
    end
  end

  assign bus_rdata = (rd_src == RD_MEM) ? mem_bus_q : reg_q;

  // R2
  ctrl_update_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && hit_ctrl) |=> (lock == $past(bus_wdata[1]) && run == $past(bus_wdata[0])));

  // R7
  shift_init_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (shamt == SHIFT_W'(SHIFT_INIT)));

  // R11
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !hit_mem && !hit_ctrl && !hit_shift && !hit_offs)
      |=> ($stable(run) && $stable(lock) && $stable(shamt) && $stable(offs)));

  // R1
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  // R11
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0 && !bus_rvalid));
endmodule

// File: rtl/tpg_sequencer.sv
`timescale 1ns/1ps
module tpg_sequencer
  import tpg_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 64,
  parameter int LANE_W = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int WA_W  = IDX_W - SEL_W,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  output logic [WA_W-1:0]  rd_word,
  output logic             s1_valid,
  output logic             s1_run,
  output logic [SEL_W-1:0] s1_sel,
  output logic [DW-1:0]    s1_data
);
  logic [IDX_W-1:0] idx;
  logic             at_last;

  assign at_last = (idx == IDX_W'(DEPTH - 1));
  assign rd_word = idx[IDX_W-1:SEL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (restart) begin
      idx <= '0;
    end else if (run && in_valid) begin
      idx <= at_last ? '0 : idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_run   <= 1'b0;
      s1_sel   <= '0;
      s1_data  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_run   <= run;
      s1_sel   <= idx[SEL_W-1:0];
      s1_data  <= in_data;
    end
  end

  // R5
  restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (idx == '0));

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (run && in_valid && !restart && at_last) |=> (idx == '0));

  // R4
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && in_valid && !restart && !at_last) |=> (idx == $past(idx) + 1'b1));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !restart) |=> $stable(idx));
endmodule

// File: rtl/tpg_lane_calc.sv
`timescale 1ns/1ps
module tpg_lane_calc
  import tpg_pkg::*;
#(
  parameter int LANES   = 64,
  parameter int LANE_W  = 8,
  parameter int SHIFT_W = 4,
  localparam int DW = LANES * LANE_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         s1_valid,
  input  logic                         s1_run,
  input  logic [BUS_DW-1:0]            word,
  input  logic [SEL_W-1:0]             sel,
  input  logic [DW-1:0]                s1_data,
  input  logic [LANES-1:0][LANE_W-1:0] offs,
  input  logic [SHIFT_W-1:0]           shamt,
  output logic                         out_valid,
  output logic [DW-1:0]                out_data
);
  logic [SMP_W-1:0] sample;
  assign sample = word[sel*SMP_W +: SMP_W];

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= s1_valid;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] sum, shifted;
    assign sum     = LANE_W'(sample) + offs[g];
    assign shifted = sum << shamt;

    always_ff @(posedge clk) begin
      if (rst)         out_data[g*LANE_W +: LANE_W] <= '0;
      else if (s1_run) out_data[g*LANE_W +: LANE_W] <= shifted;
      else             out_data[g*LANE_W +: LANE_W] <= s1_data[g*LANE_W +: LANE_W];
    end
  end

  // R7
  shift_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_run && (int'(shamt) >= LANE_W)) |=> (out_data == '0));
endmodule

// File: rtl/lane_pattern_source.sv
`timescale 1ns/1ps
module lane_pattern_source
  import tpg_pkg::*;
#(
  parameter int DEPTH      = 1024,
  parameter int LANES      = 64,
  parameter int LANE_W     = 8,
  parameter int SHIFT_W    = 4,
  parameter int SHIFT_INIT = 4,
  localparam int DW        = LANES * LANE_W,
  localparam int MEM_WORDS = DEPTH / SMP_PER_WORD,
  localparam int WA_W      = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_data,
  output logic              out_valid,
  output logic [DW-1:0]     out_data,
  output logic              lock_flag
);
  logic                         mem_we, run, restart;
  logic [WA_W-1:0]              mem_addr, rd_word;
  logic [BUS_DW-1:0]            mem_wdata, mem_bus_q, mem_pat_q;
  logic [SHIFT_W-1:0]           shamt;
  logic [LANES-1:0][LANE_W-1:0] offs;
  logic                         s1_valid, s1_run;
  logic [SEL_W-1:0]             s1_sel;
  logic [DW-1:0]                s1_data;

  tpg_regfile #(
    .LANES(LANES), .LANE_W(LANE_W), .SHIFT_W(SHIFT_W),
    .SHIFT_INIT(SHIFT_INIT), .MEM_WORDS(MEM_WORDS)
  ) i_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mem_bus_q(mem_bus_q),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .run(run), .lock(lock_flag), .restart(restart), .shamt(shamt),
    .offs(offs), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  tpg_pattern_mem #(.WORDS(MEM_WORDS), .DW(BUS_DW)) i_mem (
    .clk(clk), .wr_en(mem_we), .bus_addr(mem_addr), .wr_data(mem_wdata),
    .pat_addr(rd_word), .bus_q(mem_bus_q), .pat_q(mem_pat_q)
  );

  tpg_sequencer #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) i_seq (
    .clk(clk), .rst(rst), .run(run), .restart(restart),
    .in_valid(in_valid), .in_data(in_data), .rd_word(rd_word),
    .s1_valid(s1_valid), .s1_run(s1_run), .s1_sel(s1_sel), .s1_data(s1_data)
  );

  tpg_lane_calc #(.LANES(LANES), .LANE_W(LANE_W), .SHIFT_W(SHIFT_W)) i_calc (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_run(s1_run),
    .word(mem_pat_q), .sel(s1_sel), .s1_data(s1_data), .offs(offs),
    .shamt(shamt), .out_valid(out_valid), .out_data(out_data)
  );

  // R6
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  // R6
  invalid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);
endmodule

// File: tb/test_lane_pattern_source.sv
`timescale 1ns/1ps
module test_lane_pattern_source;
  localparam int LANES = 64, LW = 8, DEPTH = 1024, DW = LANES * LW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst = 1'b1;
  logic           bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0]    bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic           bus_rvalid;
  logic           in_valid = 1'b0;
  logic [DW-1:0]  in_data = '0;
  logic           out_valid;
  logic [DW-1:0]  out_data;
  logic           lock_flag;

  lane_pattern_source i_lane_pattern_source (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .lock_flag(lock_flag)
  );

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R10";
  bit    done = 1'b0;

  // behavioural reference state
  int           m_mem [DEPTH];
  int           m_offs [LANES];
  int           m_shift, m_idx;
  bit           m_run, m_lock;
  bit           s1_v, s1_r;
  int           s1_smp;
  logic [DW-1:0] s1_d;
  logic          exp_valid;
  logic [DW-1:0] exp_data;
  logic          exp_rvalid;
  logic [31:0]   exp_rdata;

  function automatic logic [31:0] model_read(logic [11:0] a);
    int k;
    if (a[1:0] != 2'b00) return 32'h0;
    if (a < 12'h400) begin
      k = int'(a) / 4;
      return {8'(m_mem[4*k+3]), 8'(m_mem[4*k+2]), 8'(m_mem[4*k+1]), 8'(m_mem[4*k])};
    end
    if (a == 12'h400) return {30'h0, m_lock, m_run};
    if (a == 12'h404) return 32'(m_shift);
    if (a >= 12'h800 && a < 12'h900) return 32'(m_offs[(int'(a) - 'h800) / 4]);
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_lock = 0; m_shift = 4; m_idx = 0;
      for (int i = 0; i < LANES; i++) m_offs[i] = 0;
      s1_v = 0; s1_r = 0; s1_smp = 0; s1_d = '0;
      exp_valid = 0; exp_data = '0; exp_rvalid = 0; exp_rdata = '0;
    end else begin
      exp_valid = s1_v;
      for (int i = 0; i < LANES; i++) begin
        int v;
        if (s1_r) begin
          v = (s1_smp + m_offs[i]) & 255;
          v = (m_shift >= LW) ? 0 : ((v << m_shift) & 255);
        end else begin
          v = int'(s1_d[i*LW +: LW]);
        end
        exp_data[i*LW +: LW] = LW'(v);
      end
      exp_rvalid = bus_rd;
      exp_rdata  = bus_rd ? model_read(bus_addr) : 32'h0;
      s1_v = in_valid; s1_r = m_run; s1_smp = m_mem[m_idx]; s1_d = in_data;
      if (bus_wr && bus_addr == 12'h400 && bus_wdata[0] && !m_run) m_idx = 0;
      else if (m_run && in_valid) m_idx = (m_idx + 1) % DEPTH;
      if (bus_wr && bus_addr[1:0] == 2'b00) begin
        if (bus_addr < 12'h400) begin
          for (int j = 0; j < 4; j++) m_mem[int'(bus_addr) + j] = int'(bus_wdata[8*j +: 8]);
        end else if (bus_addr == 12'h400) begin
          m_run = bus_wdata[0]; m_lock = bus_wdata[1];
        end else if (bus_addr == 12'h404) begin
          m_shift = int'(bus_wdata[3:0]);
        end else if (bus_addr >= 12'h800 && bus_addr < 12'h900) begin
          m_offs[(int'(bus_addr) - 'h800) / 4] = int'(bus_wdata[7:0]);
        end
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_cmp++;
      if (out_valid !== exp_valid || out_data !== exp_data ||
          bus_rvalid !== exp_rvalid || bus_rdata !== exp_rdata) begin
        n_bad++;
        $display("FAIL %s: valid %0b exp %0b rvalid %0b exp %0b rdata %h exp %h data %h exp %h",
                 cur_req, out_valid, exp_valid, bus_rvalid, exp_rvalid,
                 bus_rdata, exp_rdata, out_data, exp_data);
      end
    end
  end

  // live stream driver
  bit stream_on = 0, gapped = 1;
  int scnt = 0;
  always @(negedge clk) begin
    if (stream_on) begin
      scnt++;
      in_valid = gapped ? ((scnt % 4) != 3) : 1'b1;
      for (int i = 0; i < LANES; i++) in_data[i*LW +: LW] = LW'(scnt * 13 + i * 29);
    end else begin
      in_valid = 1'b0;
    end
  end

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(out_valid == 1'b0, "R10", "out_valid", 32'(out_valid), 0);
    check(out_data == '0, "R10", "out_data", out_data[31:0], 0);
    check(bus_rdata == '0 && !bus_rvalid, "R10", "bus_rdata", bus_rdata, 0);
    check(lock_flag == 1'b0, "R10", "lock_flag", 32'(lock_flag), 0);
    rst = 1'b0;
    @(negedge clk);

    cur_req = "R7"; rd(12'h404);
    cur_req = "R2"; rd(12'h400);

    cur_req = "R1";
    for (int k = 0; k < 256; k++) begin
      logic [31:0] w;
      for (int j = 0; j < 4; j++) w[8*j +: 8] = 8'((4*k + j) * 37 + 11);
      wr(12'(4*k), w);
    end
    rd(12'h000); rd(12'h004); rd(12'h200); rd(12'h3FC);

    cur_req = "R8";
    for (int n = 0; n < LANES; n++) wr(12'h800 + 12'(4*n), 32'((4*n + 1) & 255));
    rd(12'h814); rd(12'h8FC);

    cur_req = "R6";
    wr(12'h400, 32'h2);
    idle(1);
    check(lock_flag == 1'b1, "R2", "lock_flag after 0x2", 32'(lock_flag), 1);
    stream_on = 1; gapped = 1;
    idle(40);

    cur_req = "R3"; wr(12'h400, 32'h3); idle(60);
    cur_req = "R4"; gapped = 0; idle(1100); gapped = 1; idle(50);

    cur_req = "R5";
    wr(12'h400, 32'h3); idle(20);
    wr(12'h400, 32'h2); idle(10);
    wr(12'h400, 32'h3); idle(30);

    cur_req = "R7";
    wr(12'h404, 32'h0); idle(20);
    wr(12'h404, 32'h7); idle(20);
    wr(12'h404, 32'h8); idle(20);
    wr(12'h404, 32'hF); idle(20);
    wr(12'h404, 32'h3); idle(10);

    cur_req = "R8";
    for (int n = 0; n < LANES; n++) wr(12'h800 + 12'(4*n), 32'h0);
    idle(4);
    for (int c = 0; c < 8; c++) begin
      if (out_valid) begin
        bit same = 1;
        for (int i = 1; i < LANES; i++)
          if (out_data[i*LW +: LW] !== out_data[LW-1:0]) same = 0;
        check(same, "R8", "lanes identical", out_data[31:0], {4{out_data[7:0]}});
      end
      @(negedge clk);
    end

    cur_req = "R9";
    for (int j = 0; j < 20; j++) wr(12'(4 * ((j * 3) % 256)), 32'hA5A5_0000 + 32'(j));
    idle(1400);

    cur_req = "R11";
    wr(12'h40C, 32'hFFFF_FFFF);
    wr(12'h402, 32'h0);
    wr(12'hC00, 32'h1234_5678);
    rd(12'h40C); rd(12'h402); rd(12'hC00); rd(12'h900);
    idle(3);
    check(lock_flag == 1'b1, "R11", "lock_flag after ignored writes", 32'(lock_flag), 1);
    rd(12'h400);

    cur_req = "R6";
    wr(12'h400, 32'h0); idle(30);
    stream_on = 0; idle(5);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule